// File: doc/BRIEF.md
# UART Interrupt Status and Enable

This block gathers fourteen single-cycle event pulses produced around a UART (transmit and receive FIFO watermarks, line errors, flow-control changes, break completion and bus error responses) into a sticky pending register. A companion mask register selects which pending events may raise the single active-high, level-sensitive interrupt line toward the processor.

Software reads the pending register to find the cause of an interrupt and acknowledges by writing back ones to the bits it has handled, so bits written as zero stay pending. Two group outputs summarise the masked receive-path and transmit-path events, which lets a handler pick the path to service without decoding every bit. Register access goes through a plain address, write-strobe and data port, and the read data is a combinational function of the address.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Pending bit i is set by a pulse on evt_pulse[i], for i from 0 to 13: 0 tx holding empty, 1 rx data ready, 2 tx FIFO low-water, 3 tx FIFO empty, 4 rx FIFO high-water, 5 rx FIFO full, 6 tx underrun, 7 rx overrun, 8 parity error, 9 framing error, 10 CTS change, 11 rx idle timeout, 12 break sent, 13 bus error. The pending register reads at byte offset 0x18 with bit i in data bit i and bits 31..14 reading zero.
- R2: A pending bit latches on its event whether or not its mask bit is set, and stays set until cleared.
- R3: A write at offset 0x18 clears every pending bit whose data bit is one.
- R4: Pending bits written as zero, and all pending bits in cycles with no write and no event, keep their value.
- R5: When an event pulse and a clearing write for the same bit fall in one cycle, the bit is set afterwards.
- R6: A write at offset 0x14 replaces the mask with data bits 13..0; data bits 31..14 are ignored and the mask reads back at 0x14 with bits 31..14 zero.
- R7: irq_o is high exactly when some bit is both pending and masked in.
- R8: rx_irq_o is high exactly when one of pending bits 4, 5, 7, 8, 9 or 11 is masked in.
- R9: tx_irq_o is high exactly when one of pending bits 2, 3 or 6 is masked in.
- R10: Reset clears pending and mask registers, so irq_o, rx_irq_o and tx_irq_o are low.
- R11: Reads at any other offset return zero and writes there change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse | input | 14 | One-cycle event pulses, bit i sets pending bit i |
| reg_addr | input | 8 | Byte offset of register access |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq_o | output | 1 | Level interrupt, active high |
| rx_irq_o | output | 1 | Masked receive-group summary |
| tx_irq_o | output | 1 | Masked transmit-group summary |

## Verification
The bench aims at the collision of an event with an acknowledge of the same bit; a design that lets the clear win would lose an event and leave the interrupt silent. It latches events while masked off and then enables them, which exposes a design that gates the pending bit instead of the output, and it writes ones into the unused upper data bits and to an unmapped offset to catch sloppy decoding. A walk over every event bit checks the group summaries, where a misplaced bit in either group mask would raise the wrong path or none.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int EVT_N = 14;

    localparam int B_TX_HOLD_EMPTY = 0;
    localparam int B_RX_READY      = 1;
    localparam int B_TX_LOW_WATER  = 2;
    localparam int B_TX_EMPTY      = 3;
    localparam int B_RX_HIGH_WATER = 4;
    localparam int B_RX_FULL       = 5;
    localparam int B_TX_UNDERRUN   = 6;
    localparam int B_RX_OVERRUN    = 7;
    localparam int B_PARITY_ERR    = 8;
    localparam int B_FRAMING_ERR   = 9;
    localparam int B_CTS_CHANGE    = 10;
    localparam int B_RX_IDLE       = 11;
    localparam int B_BREAK_SENT    = 12;
    localparam int B_BUS_ERR       = 13;

    localparam logic [EVT_N-1:0] RX_GROUP_MASK =
        EVT_N'((1 << B_RX_HIGH_WATER) | (1 << B_RX_FULL) | (1 << B_RX_OVERRUN) |
               (1 << B_PARITY_ERR) | (1 << B_FRAMING_ERR) | (1 << B_RX_IDLE));

    localparam logic [EVT_N-1:0] TX_GROUP_MASK =
        EVT_N'((1 << B_TX_LOW_WATER) | (1 << B_TX_EMPTY) | (1 << B_TX_UNDERRUN));

    typedef struct packed {
        logic [EVT_N-1:0] pend;
        logic [EVT_N-1:0] mask;
    } irq_state_t;

endpackage

// File: rtl/uart_irq_decode.sv
module uart_irq_decode #(
    parameter int ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] MASK_OFFS = 8'h14,
    parameter logic [ADDR_W-1:0] PEND_OFFS = 8'h18
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output logic              sel_mask,
    output logic              sel_pend,
    output logic              wr_mask,
    output logic              wr_pend
);
    always_comb begin
        sel_mask = (addr == MASK_OFFS);
        sel_pend = (addr == PEND_OFFS);
        wr_mask  = we && sel_mask;
        wr_pend  = we && sel_pend;
    end
endmodule

// File: rtl/uart_irq_bank.sv
module uart_irq_bank
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_N-1:0] evt,
    input  logic             wr_mask,
    input  logic             wr_pend,
    input  logic [EVT_N-1:0] wval,
    output logic [EVT_N-1:0] pend_q,
    output logic [EVT_N-1:0] mask_q
);
    irq_state_t st_d, st_q;
    logic [EVT_N-1:0] clr_d;

    always_comb begin
        st_d  = st_q;
        clr_d = wr_pend ? wval : '0;
        if (wr_mask) begin
            st_d.mask = wval;
        end
        // acknowledge first, then a simultaneous event sets the bit again
        for (int i = 0; i < EVT_N; i++) begin
            st_d.pend[i] = (st_q.pend[i] && !clr_d[i]) || evt[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_q = st_q.pend;
    assign mask_q = st_q.mask;
endmodule

// File: rtl/uart_irq_combine.sv
module uart_irq_combine
    import uart_irq_pkg::*;
(
    input  logic [EVT_N-1:0] pend,
    input  logic [EVT_N-1:0] mask,
    output logic             irq,
    output logic             rx_irq,
    output logic             tx_irq
);
    logic [EVT_N-1:0] live;
    logic [EVT_N-1:0] rx_live;
    logic [EVT_N-1:0] tx_live;

    genvar g;
    generate
        for (g = 0; g < EVT_N; g++) begin : g_bit
            assign live[g]    = pend[g] & mask[g];
            assign rx_live[g] = live[g] & RX_GROUP_MASK[g];
            assign tx_live[g] = live[g] & TX_GROUP_MASK[g];
        end
    endgenerate

    always_comb begin
        irq    = |live;
        rx_irq = |rx_live;
        tx_irq = |tx_live;
    end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] MASK_OFFS = 8'h14,
    parameter logic [ADDR_W-1:0] PEND_OFFS = 8'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EVT_N-1:0]  evt_pulse,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o,
    output logic              rx_irq_o,
    output logic              tx_irq_o
);
    localparam int PAD_W = DATA_W - EVT_N;

    logic             sel_mask, sel_pend, wr_mask, wr_pend;
    logic [EVT_N-1:0] pend_q, mask_q;
    logic             unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:EVT_N];

    uart_irq_decode #(
        .ADDR_W   (ADDR_W),
        .MASK_OFFS(MASK_OFFS),
        .PEND_OFFS(PEND_OFFS)
    ) u_dec (
        .addr    (reg_addr),
        .we      (reg_we),
        .sel_mask(sel_mask),
        .sel_pend(sel_pend),
        .wr_mask (wr_mask),
        .wr_pend (wr_pend)
    );

    uart_irq_bank u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt_pulse),
        .wr_mask(wr_mask),
        .wr_pend(wr_pend),
        .wval   (reg_wdata[EVT_N-1:0]),
        .pend_q (pend_q),
        .mask_q (mask_q)
    );

    uart_irq_combine u_comb (
        .pend  (pend_q),
        .mask  (mask_q),
        .irq   (irq_o),
        .rx_irq(rx_irq_o),
        .tx_irq(tx_irq_o)
    );

    always_comb begin
        reg_rdata = '0;
        if (sel_mask) begin
            reg_rdata = {{PAD_W{1'b0}}, mask_q};
        end else if (sel_pend) begin
            reg_rdata = {{PAD_W{1'b0}}, pend_q};
        end
    end
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk #(
    parameter int ADDR_W = 8,
    parameter int EVT_W  = 14,
    parameter logic [ADDR_W-1:0] PEND_OFFS = 8'h18
) (
    input logic              clk,
    input logic              rst_n,
    input logic [EVT_W-1:0]  evt_pulse,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_we,
    input logic [EVT_W-1:0]  wlow,
    input logic [EVT_W-1:0]  pend_q,
    input logic [EVT_W-1:0]  mask_q,
    input logic              irq_o
);
    logic ack;
    assign ack = reg_we && (reg_addr == PEND_OFFS);

    // R2 and R5: every pulsed bit is pending in the next cycle
    assert_evt_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pulse != '0) |=> ((pend_q & $past(evt_pulse)) == $past(evt_pulse)));

    // R5: a collision of acknowledge and event keeps the bit
    assert_evt_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && ((wlow & evt_pulse) != '0)) |=> ((pend_q & $past(wlow & evt_pulse)) == $past(wlow & evt_pulse)));

    // R3: acknowledged bits without a new event are gone
    assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> ((pend_q & $past(wlow & ~evt_pulse)) == '0));

    // R4: with no acknowledge and no event the pending register holds
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack && evt_pulse == '0) |=> $stable(pend_q));

    // R7: with nothing masked in the line is quiet
    assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq_o);
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .EVT_W    (uart_irq_pkg::EVT_N),
    .PEND_OFFS(PEND_OFFS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_pulse(evt_pulse),
    .reg_addr (reg_addr),
    .reg_we   (reg_we),
    .wlow     (reg_wdata[uart_irq_pkg::EVT_N-1:0]),
    .pend_q   (pend_q),
    .mask_q   (mask_q),
    .irq_o    (irq_o)
);

// File: tb/uart_irq_ctrl_test.sv
module uart_irq_ctrl_test;

    typedef struct packed {
        logic [13:0] evt;
        logic        we;
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic [13:0] x_pend;
        logic [13:0] x_mask;
        logic        x_irq;
        logic        x_rx;
        logic        x_tx;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{14'h0001, 1'b0, 8'h00, 32'h0000_0000, 14'h0001, 14'h0000, 1'b0, 1'b0, 1'b0}, // R1 R2 masked event latches
        '{14'h0000, 1'b1, 8'h14, 32'hFFFF_0004, 14'h0001, 14'h0004, 1'b0, 1'b0, 1'b0}, // R6 upper bits ignored
        '{14'h0004, 1'b0, 8'h00, 32'h0000_0000, 14'h0005, 14'h0004, 1'b1, 1'b0, 1'b1}, // R7 R9
        '{14'h0000, 1'b1, 8'h14, 32'h0000_0B30, 14'h0005, 14'h0B30, 1'b0, 1'b0, 1'b0}, // R6 R7
        '{14'h0200, 1'b0, 8'h00, 32'h0000_0000, 14'h0205, 14'h0B30, 1'b1, 1'b1, 1'b0}, // R8 framing
        '{14'h0000, 1'b1, 8'h18, 32'h0000_0004, 14'h0201, 14'h0B30, 1'b1, 1'b1, 1'b0}, // R3 R4
        '{14'h0200, 1'b1, 8'h18, 32'h0000_0200, 14'h0201, 14'h0B30, 1'b1, 1'b1, 1'b0}, // R5 collision
        '{14'h0000, 1'b1, 8'h18, 32'hFFFF_FFFF, 14'h0000, 14'h0B30, 1'b0, 1'b0, 1'b0}, // R3 clear all
        '{14'h0000, 1'b1, 8'h1C, 32'h0000_FFFF, 14'h0000, 14'h0B30, 1'b0, 1'b0, 1'b0}, // R11 stray write
        '{14'h2000, 1'b0, 8'h00, 32'h0000_0000, 14'h2000, 14'h0B30, 1'b0, 1'b0, 1'b0}, // R2 bus error masked
        '{14'h0000, 1'b1, 8'h14, 32'h0000_2000, 14'h2000, 14'h2000, 1'b1, 1'b0, 1'b0}  // R7 enable later
    };

    localparam logic [13:0] RX_BITS = 14'h0BB0; // bits 4 5 7 8 9 11
    localparam logic [13:0] TX_BITS = 14'h004C; // bits 2 3 6

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] evt_pulse = '0;
    logic [7:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o, rx_irq_o, tx_irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    uart_irq_ctrl uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_pulse(evt_pulse),
        .reg_addr (reg_addr),
        .reg_we   (reg_we),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .irq_o    (irq_o),
        .rx_irq_o (rx_irq_o),
        .tx_irq_o (tx_irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic read_reg(input logic [7:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic observe(input string req, input logic [13:0] p, input logic [13:0] m,
                           input logic i, input logic rx, input logic tx);
        logic [31:0] v;
        read_reg(8'h18, v);
        check({req, " pending"}, v, {18'h0, p});
        read_reg(8'h14, v);
        check({req, " mask"}, v, {18'h0, m});
        check({req, " irq"}, {31'h0, irq_o}, {31'h0, i});
        check({req, " rx"}, {31'h0, rx_irq_o}, {31'h0, rx});
        check({req, " tx"}, {31'h0, tx_irq_o}, {31'h0, tx});
    endtask

    task automatic step(input logic [13:0] e, input logic w, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        evt_pulse = e;
        reg_we    = w;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        evt_pulse = '0;
        reg_we    = 1'b0;
        reg_wdata = '0;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10 reset state
        observe("R10", 14'h0, 14'h0, 1'b0, 1'b0, 1'b0);

        for (int k = 0; k < NV; k++) begin
            step(VEC[k].evt, VEC[k].we, VEC[k].addr, VEC[k].wdata);
            observe($sformatf("vector %0d", k), VEC[k].x_pend, VEC[k].x_mask,
                    VEC[k].x_irq, VEC[k].x_rx, VEC[k].x_tx);
        end

        // R11 unmapped offset reads zero while state is nonzero
        read_reg(8'h1C, v);
        check("R11 read", v, 32'h0);
        read_reg(8'h10, v);
        check("R11 read low", v, 32'h0);

        // R1 R8 R9 walk every event bit with everything masked in
        step(14'h0, 1'b1, 8'h14, 32'h0000_3FFF);
        step(14'h0, 1'b1, 8'h18, 32'h0000_3FFF);
        for (int b = 0; b < 14; b++) begin
            logic [13:0] one;
            one = 14'(1 << b);
            step(one, 1'b0, 8'h00, 32'h0);
            observe($sformatf("R1 R8 R9 bit %0d", b), one, 14'h3FFF, 1'b1,
                    (RX_BITS & one) != 0, (TX_BITS & one) != 0);
            step(14'h0, 1'b1, 8'h18, {18'h0, one});
            observe("R3 ack", 14'h0, 14'h3FFF, 1'b0, 1'b0, 1'b0);
        end

        // R4 zero-written bits survive an acknowledge of others
        step(14'h3FFF, 1'b0, 8'h00, 32'h0);
        step(14'h0, 1'b1, 8'h18, 32'h0000_2AAA);
        observe("R4 partial ack", 14'h1555, 14'h3FFF, 1'b1, 1'b1, 1'b1);

        // R10 reset in the middle of activity
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        observe("R10 mid-run", 14'h0, 14'h0, 1'b0, 1'b0, 1'b0);

        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule